// File: doc/BRIEF.md
# Calendar Real-Time Clock with Tick Wakeup

This block keeps wall-clock time as a set of calendar counters (seconds, minutes, hours, day, month and a two-digit year counted from 2000) inside a small byte-addressed register file. A host reaches the registers through a simple one-byte-per-cycle read/write port. A flag on the port loads a new address; every later access without that flag moves on to the next address, so the six time bytes can be read or written as one burst.

The counters advance once per second. The second is derived from a reference pulse input that a divider counts down. Software marks the stored time as trustworthy by setting a monitor bit in the year byte whenever it writes the time. A tick alarm can raise a sticky event bit every second, or only at each minute boundary. The event bit is cleared by writing a one to it. A control register carries a shutdown request and a wakeup request. If tick wakeup is enabled, a tick that fires while shutdown is pending turns the shutdown into a wakeup.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0, day and month read 1, the monitor bit (year register bit 6) is 0, the event register reads 0 and both control outputs are low.
- R2: The time counters are at 0x40 (seconds, 6 bits), 0x41 (minutes, 6 bits), 0x42 (hours, 5 bits), 0x43 (day, 5 bits), 0x44 (month, 4 bits) and 0x45 (year, 6 bits in [5:0]). Bits above each field read 0.
- R3: An access with `busFirst` high uses `busAddr`. An access with `busFirst` low uses the previous access address plus one. Read data appears on `busRdata` the cycle after the read.
- R4: Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours. Hours roll from 23 to 0 and carry into the day.
- R5: The day rolls to 1 after day 30 in months 4, 6, 9 and 11, after day 31 in the other months, and in month 2 after day 29 when year[1:0] is 0 and after day 28 otherwise. The month rolls from 12 to 1 and carries into the year, and the year wraps from 63 to 0.
- R6: Year register bit 6 is the monitor bit. It holds the value last written to it and time counting never changes it.
- R7: The seconds count advances once for every DIV reference pulses. Any write to 0x40..0x45 restarts the divider, so the next advance needs a full DIV pulses.
- R8: Register 0x4B bit 7 enables the tick. Register 0x4A bit 4 selects the tick type (0 = every second, 1 = only when seconds roll from 59) and bit 5 enables tick wakeup. Other bits of these registers read 0. An enabled tick sets event bit 0 of register 0x06 (output `tickFlag`). No event is set while the tick is disabled.
- R9: Writing 1 to bit 0 of register 0x06 clears the event. Writing 0 there leaves it unchanged.
- R10: Register 0x13 bit 1 is the shutdown request and bit 2 the wakeup request. They drive `shutdownReq` and `wakeupReq` and read back in place.
- R11: A tick that fires while tick wakeup is enabled and shutdown is requested sets the wakeup bit and clears the shutdown bit.
- R12: Addresses outside the map read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refPulse | input | 1 | Reference pulse, DIV pulses per second |
| busValid | input | 1 | Access strobe for one byte |
| busFirst | input | 1 | Load busAddr as the access address |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Start address of a burst |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid the cycle after a read |
| tickFlag | output | 1 | Sticky tick event bit |
| shutdownReq | output | 1 | Shutdown request bit |
| wakeupReq | output | 1 | Wakeup request bit |

## Verification
The bench targets the carry chain at 23:59:59 and at the month ends. A design that tested the wrong bound would stop at 24:00, skip 29 February in year 4, or leave the year unwrapped at 63. It checks that writing a counter restarts the divider; a design that kept the partial count would advance the seconds early. The minute-type tick must fire only when seconds leave 59, not on every second. The write-one-to-clear event must ignore a written zero. A tick wakeup taken while shutdown is pending must also drop the shutdown bit; a design that kept it would leave both requests high.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W = 5;
  localparam int MON_W = 4;
  localparam int YEAR_W = 6;
  localparam int NUM_CNT = 6;

  localparam logic [ADDR_W-1:0] ADDR_EVT   = 8'h06;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h13;
  localparam logic [ADDR_W-1:0] ADDR_SEC   = 8'h40;
  localparam logic [ADDR_W-1:0] ADDR_MIN   = 8'h41;
  localparam logic [ADDR_W-1:0] ADDR_HOUR  = 8'h42;
  localparam logic [ADDR_W-1:0] ADDR_DAY   = 8'h43;
  localparam logic [ADDR_W-1:0] ADDR_MON   = 8'h44;
  localparam logic [ADDR_W-1:0] ADDR_YEAR  = 8'h45;
  localparam logic [ADDR_W-1:0] ADDR_TCFG  = 8'h4A;
  localparam logic [ADDR_W-1:0] ADDR_TEN   = 8'h4B;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic              cntWr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } acc_t;

  function automatic logic [DAY_W-1:0] lastDay(input logic [MON_W-1:0] mon,
                                               input logic [YEAR_W-1:0] yr);
    logic [DAY_W-1:0] d;
    case (mon)
      4'd2:                      d = (yr[1:0] == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   d = 5'd30;
      default:                   d = 5'd31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rstN,
  input  logic refPulse,
  input  logic restart,
  output logic secPulse
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign secPulse = refPulse && (cnt == LAST) && !restart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (refPulse) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busFirst,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output acc_t              acc
);
  localparam logic [ADDR_W-1:0] CNT_LAST = ADDR_SEC + ADDR_W'(NUM_CNT - 1);

  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] addrNow;

  assign addrNow = busFirst ? busAddr : ptr;

  always_comb begin
    acc.wrEn  = busValid && busWrite;
    acc.rdEn  = busValid && !busWrite;
    acc.addr  = addrNow;
    acc.wdata = busWdata;
    acc.cntWr = busValid && busWrite && (addrNow >= ADDR_SEC) && (addrNow <= CNT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ptr <= '0;
    else if (busValid) ptr <= addrNow + 1'b1;
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  acc_t              acc,
  input  logic              secPulse,
  output logic [DATA_W-1:0] rdata,
  output logic              tickFlag,
  output logic              shutdownReq,
  output logic              wakeupReq
);
  logic [SEC_W-1:0]  sec;
  logic [MIN_W-1:0]  minute;
  logic [HOUR_W-1:0] hour;
  logic [DAY_W-1:0]  day;
  logic [MON_W-1:0]  mon;
  logic [YEAR_W-1:0] year;
  logic              monitor;
  logic              tickOn, tickType, tickWake;
  logic              evt, shut, wake;

  logic secWrap, minWrap, hourWrap, dayWrap, monWrap, tickFire;

  always_comb begin
    secWrap  = sec >= SEC_W'(59);
    minWrap  = secWrap && (minute >= MIN_W'(59));
    hourWrap = minWrap && (hour >= HOUR_W'(23));
    dayWrap  = hourWrap && (day >= lastDay(mon, year));
    monWrap  = dayWrap && (mon >= MON_W'(12));
    tickFire = secPulse && tickOn && (!tickType || secWrap);
  end

  // Calendar counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sec <= '0; minute <= '0; hour <= '0;
      day <= DAY_W'(1); mon <= MON_W'(1); year <= '0; monitor <= 1'b0;
    end else if (acc.cntWr) begin
      case (acc.addr)
        ADDR_SEC:  sec    <= acc.wdata[SEC_W-1:0];
        ADDR_MIN:  minute <= acc.wdata[MIN_W-1:0];
        ADDR_HOUR: hour   <= acc.wdata[HOUR_W-1:0];
        ADDR_DAY:  day    <= acc.wdata[DAY_W-1:0];
        ADDR_MON:  mon    <= acc.wdata[MON_W-1:0];
        default: begin
          year    <= acc.wdata[YEAR_W-1:0];
          monitor <= acc.wdata[6];
        end
      endcase
    end else if (secPulse) begin
      sec <= secWrap ? '0 : sec + 1'b1;
      if (secWrap)  minute <= minWrap ? '0 : minute + 1'b1;
      if (minWrap)  hour   <= hourWrap ? '0 : hour + 1'b1;
      if (hourWrap) day    <= dayWrap ? DAY_W'(1) : day + 1'b1;
      if (dayWrap)  mon    <= monWrap ? MON_W'(1) : mon + 1'b1;
      if (monWrap)  year   <= year + 1'b1;
    end
  end

  // Tick configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickOn <= 1'b0; tickType <= 1'b0; tickWake <= 1'b0;
    end else if (acc.wrEn) begin
      if (acc.addr == ADDR_TCFG) begin
        tickWake <= acc.wdata[5];
        tickType <= acc.wdata[4];
      end
      if (acc.addr == ADDR_TEN) tickOn <= acc.wdata[7];
    end
  end

  // Event latch and control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evt <= 1'b0; shut <= 1'b0; wake <= 1'b0;
    end else begin
      if (tickFire) evt <= 1'b1;
      else if (acc.wrEn && acc.addr == ADDR_EVT && acc.wdata[0]) evt <= 1'b0;

      if (tickFire && tickWake && shut) begin
        shut <= 1'b0;
        wake <= 1'b1;
      end else if (acc.wrEn && acc.addr == ADDR_CTRL) begin
        shut <= acc.wdata[1];
        wake <= acc.wdata[2];
      end
    end
  end

  // Registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (acc.rdEn) begin
      case (acc.addr)
        ADDR_EVT:  rdata <= {7'd0, evt};
        ADDR_CTRL: rdata <= {5'd0, wake, shut, 1'b0};
        ADDR_SEC:  rdata <= DATA_W'(sec);
        ADDR_MIN:  rdata <= DATA_W'(minute);
        ADDR_HOUR: rdata <= DATA_W'(hour);
        ADDR_DAY:  rdata <= DATA_W'(day);
        ADDR_MON:  rdata <= DATA_W'(mon);
        ADDR_YEAR: rdata <= {1'b0, monitor, year};
        ADDR_TCFG: rdata <= {2'b00, tickWake, tickType, 4'd0};
        ADDR_TEN:  rdata <= {tickOn, 7'd0};
        default:   rdata <= '0;
      endcase
    end
  end

  assign tickFlag    = evt;
  assign shutdownReq = shut;
  assign wakeupReq   = wake;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refPulse,
  input  logic              busValid,
  input  logic              busFirst,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              tickFlag,
  output logic              shutdownReq,
  output logic              wakeupReq
);
  acc_t accStb;
  logic secPulse;

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busFirst(busFirst),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata), .acc(accStb)
  );

  rtc_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .restart(accStb.cntWr),
    .secPulse(secPulse)
  );

  rtc_datapath u_dp (
    .clk(clk), .rstN(rstN), .acc(accStb), .secPulse(secPulse),
    .rdata(busRdata), .tickFlag(tickFlag), .shutdownReq(shutdownReq),
    .wakeupReq(wakeupReq)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input acc_t              acc,
  input logic              secPulse,
  input logic [DATA_W-1:0] busRdata,
  input logic              tickFlag,
  input logic              shutdownReq,
  input logic              wakeupReq
);
  logic ctrlWr, evtClr;
  assign ctrlWr = acc.wrEn && (acc.addr == ADDR_CTRL);
  assign evtClr = acc.wrEn && (acc.addr == ADDR_EVT) && acc.wdata[0];

  AST_SEC_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |=> !secPulse); // R7

  AST_EVT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !secPulse && !evtClr |=> $stable(tickFlag)); // R8

  AST_EVT_W1C: assert property (@(posedge clk) disable iff (!rstN)
    evtClr && !secPulse |=> !tickFlag); // R9

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && !secPulse |=> (shutdownReq == $past(acc.wdata[1])) &&
                            (wakeupReq == $past(acc.wdata[2]))); // R10

  AST_WAKE_DROPS_SHUT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeupReq) && !$past(ctrlWr) |-> !shutdownReq && $past(shutdownReq)); // R11

  AST_SEC_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    acc.rdEn && (acc.addr == ADDR_SEC) |=> busRdata[7:6] == 2'b00); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    acc.rdEn && (acc.addr == 8'h00) |=> busRdata == '0); // R12
endmodule

bind rtc_calendar rtc_calendar_chk chk_i (
  .clk(clk), .rstN(rstN), .acc(accStb), .secPulse(secPulse),
  .busRdata(busRdata), .tickFlag(tickFlag), .shutdownReq(shutdownReq),
  .wakeupReq(wakeupReq)
);

// File: tb/rtc_calendar_tb_top.sv
module rtc_calendar_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refPulse = 1'b0;
  logic busValid = 1'b0, busFirst = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0, busWdata = '0;
  logic [7:0] busRdata;
  logic tickFlag, shutdownReq, wakeupReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar #(.DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .busValid(busValid),
    .busFirst(busFirst), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tickFlag(tickFlag),
    .shutdownReq(shutdownReq), .wakeupReq(wakeupReq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit first);
    @(negedge clk);
    busValid = 1; busWrite = 1; busFirst = first; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0; busFirst = 0;
  endtask

  task automatic rd(input logic [7:0] a, input bit first, output logic [7:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busFirst = first; busAddr = a;
    @(negedge clk);
    busValid = 0; busFirst = 0;
    d = busRdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); refPulse = 1;
    end
    @(negedge clk); refPulse = 0;
  endtask

  task automatic setTime(input int s, input int m, input int h, input int d,
                         input int mo, input int y);
    wr(8'h40, 8'(s), 1); wr(0, 8'(m), 0); wr(0, 8'(h), 0);
    wr(0, 8'(d), 0); wr(0, 8'(mo), 0); wr(0, 8'(y), 0);
  endtask

  task automatic expTime(input string req, input int s, input int m, input int h,
                         input int d, input int mo, input int y);
    logic [7:0] v;
    rd(8'h40, 1, v); chk({req, " sec"}, v, s);
    rd(0, 0, v); chk({req, " min"}, v, m);
    rd(0, 0, v); chk({req, " hour"}, v, h);
    rd(0, 0, v); chk({req, " day"}, v, d);
    rd(0, 0, v); chk({req, " month"}, v, mo);
    rd(0, 0, v); chk({req, " year"}, v, y);
  endtask

  task automatic t_reset();
    chk("R1 tickFlag", tickFlag, 0);
    chk("R1 shutdownReq", shutdownReq, 0);
    chk("R1 wakeupReq", wakeupReq, 0);
    expTime("R1/R3 reset burst", 0, 0, 0, 1, 1, 0);
  endtask

  task automatic t_fields();
    logic [7:0] v;
    wr(8'h40, 8'hFF, 1); rd(8'h40, 1, v); chk("R2 sec width", v, 8'h3F);
    wr(8'h42, 8'hFF, 1); rd(8'h42, 1, v); chk("R2 hour width", v, 8'h1F);
    wr(8'h44, 8'hFF, 1); rd(8'h44, 1, v); chk("R2 month width", v, 8'h0F);
    wr(8'h45, 8'hFF, 1); rd(8'h45, 1, v); chk("R2/R6 year and monitor", v, 8'h7F);
    wr(8'h20, 8'hFF, 1); rd(8'h20, 1, v); chk("R12 unmapped read", v, 0);
    rd(8'h06, 1, v); chk("R12 event untouched", v, 0);
  endtask

  task automatic t_rollover();
    setTime(59, 59, 23, 15, 6, 8'h45);
    pulses(DIV);
    expTime("R4/R6 day carry", 0, 0, 0, 16, 6, 8'h45);
  endtask

  task automatic t_month();
    setTime(59, 59, 23, 28, 2, 1); pulses(DIV);
    expTime("R5 feb common", 0, 0, 0, 1, 3, 1);
    setTime(59, 59, 23, 28, 2, 8'h44); pulses(DIV);
    expTime("R5 feb leap", 0, 0, 0, 29, 2, 8'h44);
    setTime(59, 59, 23, 30, 4, 2); pulses(DIV);
    expTime("R5 30-day month", 0, 0, 0, 1, 5, 2);
    setTime(59, 59, 23, 31, 12, 63); pulses(DIV);
    expTime("R5 year wrap", 0, 0, 0, 1, 1, 0);
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    wr(8'h40, 10, 1);
    pulses(DIV - 1); rd(8'h40, 1, v); chk("R7 before full count", v, 10);
    pulses(1);       rd(8'h40, 1, v); chk("R7 at full count", v, 11);
    pulses(DIV - 1); wr(8'h40, 20, 1);
    pulses(DIV - 1); rd(8'h40, 1, v); chk("R7 restart holds", v, 20);
    pulses(1);       rd(8'h40, 1, v); chk("R7 restart advance", v, 21);
  endtask

  task automatic t_tick();
    logic [7:0] v;
    wr(8'h4A, 8'hFF, 1); rd(8'h4A, 1, v); chk("R8 cfg bits", v, 8'h30);
    wr(8'h4B, 8'hFF, 1); rd(8'h4B, 1, v); chk("R8 enable bit", v, 8'h80);
    wr(8'h4A, 8'h00, 1); wr(8'h06, 8'h01, 1);
    pulses(DIV); rd(8'h06, 1, v); chk("R8 second tick", v, 1);
    chk("R8 tickFlag pin", tickFlag, 1);
    wr(8'h06, 8'h00, 1); rd(8'h06, 1, v); chk("R9 write zero keeps", v, 1);
    wr(8'h06, 8'h01, 1); rd(8'h06, 1, v); chk("R9 write one clears", v, 0);
    wr(8'h4A, 8'h10, 1); wr(8'h40, 58, 1);
    pulses(DIV); rd(8'h06, 1, v); chk("R8 minute tick quiet", v, 0);
    pulses(DIV); rd(8'h06, 1, v); chk("R8 minute tick fires", v, 1);
    wr(8'h4B, 8'h00, 1); wr(8'h06, 8'h01, 1); wr(8'h4A, 8'h00, 1);
    pulses(DIV); rd(8'h06, 1, v); chk("R8 disabled no event", v, 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(8'h13, 8'h02, 1);
    chk("R10 shutdown pin", shutdownReq, 1); chk("R10 wake pin low", wakeupReq, 0);
    rd(8'h13, 1, v); chk("R10 readback", v, 8'h02);
    wr(8'h13, 8'h04, 1);
    chk("R10 wake pin", wakeupReq, 1); chk("R10 shutdown low", shutdownReq, 0);
    wr(8'h13, 8'h00, 1);
  endtask

  task automatic t_wake();
    logic [7:0] v;
    wr(8'h4B, 8'h80, 1); wr(8'h4A, 8'h00, 1); wr(8'h13, 8'h02, 1);
    pulses(DIV);
    chk("R11 no wake when disabled", wakeupReq, 0);
    chk("R11 shutdown kept", shutdownReq, 1);
    wr(8'h4A, 8'h20, 1);
    pulses(DIV);
    chk("R11 wake set", wakeupReq, 1);
    chk("R11 shutdown cleared", shutdownReq, 0);
    rd(8'h13, 1, v); chk("R11 ctrl readback", v, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_rollover();
    t_month();
    t_prescale();
    t_tick();
    t_ctrl();
    t_wake();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule